// File: doc/BRIEF.md
# Two-Channel Pattern Fill Engine

This block paints a byte-addressed memory range with a repeating pattern of two, three or four bytes. Software programs one of two fill channels (a start address, an end address, a pattern value and a width selection) and then sets that channel's go bit. The engine checks that the range is not empty. It then issues one 32-bit word write per clock to a plain synchronous memory port, using byte enables to cover unaligned edges and patterns that cross word boundaries.

When a fill ends, the channel drops its go bit and raises a sticky done bit. It also pulses that channel's own interrupt line, but only if the programmed start address is nonzero. The two channels share the memory port and never write in the same cycle. When both are waiting, channel 0 is served first.

Top module: `pattern_fill_engine`

## Requirements
- R1: Each channel has four registers, selected by reg_addr[1:0] with reg_addr[2] choosing the channel: 0 start, 1 end, 2 pattern value, 3 control. Control bit 0 is go (busy), bit 1 is done (read only), bit 2 selects the 3-byte pattern and bit 3 selects the 4-byte pattern. Writing control with bit 0 set to an idle channel sets go and clears done in the next cycle.
- R2: The range runs from start (included) to end (excluded). When end is not above start, no memory write is made and the channel still completes.
- R3: With neither width bit set, the two bytes value[7:0] and value[15:8] are written at start, start+2 and so on, for each pair whose first byte lies below end. The last pair may therefore pass end by one byte.
- R4: In 3-byte mode the bytes value[7:0], value[15:8] and value[23:16] are written in that order at each step of 3, for each triple whose first byte lies below end.
- R5: In 4-byte mode, floor((end-start)/4) copies of value, little-endian, are written back to back from start. A tail shorter than four bytes is left untouched.
- R6: When both width bits are set, 3-byte mode applies.
- R7: When a fill completes, go reads 0 and done reads 1, including when start is zero.
- R8: One cycle after completion, the channel's own irq line pulses high for exactly one cycle, but only if start is nonzero. The other line stays low.
- R9: Only one channel writes at a time. A channel triggered while the other is filling waits for it to finish. If both are waiting while the engine is idle, channel 0 starts first.
- R10: While a channel's go bit is set, every register write to that channel is ignored, including a second go.
- R11: Each write cycle drives mem_addr as a word index (byte address >> 2). Byte address a uses lane a[1:0], carried on mem_wdata[8*lane+7:8*lane] with mem_be[lane] set. Each cycle either writes at least one byte or does not write at all.
- R12: After reset, every register reads 0, mem_we is low and both irq lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | {channel, register select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | AW-2 | Memory word index |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte lane enables |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The assertions assume that the memory port accepts a write on every cycle. They also assume that no range runs past the top of the address space, since an element's final byte is then taken to fit in AW+1 bits. The bench keeps every fill inside a 256-byte space with at least ten bytes of headroom above end. It sweeps every start offset modulo 8, lengths from 0 to 12 and all four width encodings, and it builds the expected image one element at a time. It causes channel overlap only through register writes made while the other channel is filling, which is the single way the one register port allows.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    typedef enum logic [1:0] {
        PAT16 = 2'd0,
        PAT24 = 2'd1,
        PAT32 = 2'd2
    } pat_e;

    // 3-byte selection takes precedence over 4-byte selection
    function automatic pat_e pat_decode(input logic sel24, input logic sel32);
        if (sel24)      return PAT24;
        else if (sel32) return PAT32;
        else            return PAT16;
    endfunction

    function automatic logic [2:0] pat_period(input pat_e p);
        case (p)
            PAT24:   return 3'd3;
            PAT32:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    // phase of the byte at the aligned word base, given start[1:0]
    function automatic logic [1:0] first_phase(input logic [1:0] k, input logic [2:0] per);
        logic [2:0] r;
        r = {1'b0, k} % per;
        if (r == 3'd0) return 2'd0;
        else           return 2'(per - r);
    endfunction

endpackage

// File: rtl/pfe_chan_regs.sv
module pfe_chan_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          fill_done,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] stop_o,
    output logic [31:0]   value_o,
    output logic          sel24_o,
    output logic          sel32_o,
    output logic          pend_o,
    output logic          fin_o
);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] stop;
        logic [31:0]   value;
        logic          sel24;
        logic          sel32;
        logic          pend;
        logic          fin;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (fill_done) begin
            regs_d.pend = 1'b0;
            regs_d.fin  = 1'b1;
        end else if (wr_en && !regs_q.pend) begin
            case (wr_sel)
                2'd0: regs_d.start = wr_data[AW-1:0];
                2'd1: regs_d.stop  = wr_data[AW-1:0];
                2'd2: regs_d.value = wr_data;
                default: begin
                    regs_d.sel24 = wr_data[2];
                    regs_d.sel32 = wr_data[3];
                    if (wr_data[0]) begin
                        regs_d.pend = 1'b1;
                        regs_d.fin  = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_o = regs_q.start;
    assign stop_o  = regs_q.stop;
    assign value_o = regs_q.value;
    assign sel24_o = regs_q.sel24;
    assign sel32_o = regs_q.sel32;
    assign pend_o  = regs_q.pend;
    assign fin_o   = regs_q.fin;

    // R10: a busy channel keeps its configuration
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.pend && !fill_done) |=>
            (regs_q.pend && $stable(regs_q.start) && $stable(regs_q.stop) && $stable(regs_q.value)));

    // R7: completion clears go and sets done
    a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (regs_q.fin && !regs_q.pend));

    // R1: go on an idle channel arms it and clears done
    a_r1_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && wr_data[0] && !regs_q.pend) |=> (regs_q.pend && !regs_q.fin));

    // R9: only a pending channel can complete
    a_r9_done_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> regs_q.pend);

endmodule

// File: rtl/pfe_word_former.sv
module pfe_word_former
    import pfe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-3:0] word_idx_i,
    input  logic [1:0]    ph0_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] stop_i,
    input  logic [31:0]   value_i,
    input  pat_e          pat_i,
    output logic [3:0]    be_o,
    output logic [31:0]   data_o,
    output logic [1:0]    ph0_nxt_o,
    output logic          last_o
);

    localparam int XW    = AW + 1;
    localparam int LANES = 4;

    logic [2:0]    per;
    logic [XW-1:0] guard;
    logic [XW-1:0] start_x;
    logic [XW-1:0] stop_x;
    logic [XW-1:0] nxt_base;

    assign per     = pat_period(pat_i);
    assign guard   = (pat_i == PAT32) ? XW'(3) : XW'(0);
    assign start_x = {1'b0, start_i};
    assign stop_x  = {1'b0, stop_i};

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [2:0]    ph_l;
        logic [XW-1:0] addr_l;
        logic [XW-1:0] elem_l;
        logic [31:0]   shv;
        assign ph_l   = (3'(ph0_i) + 3'(L)) % per;
        assign addr_l = {1'b0, word_idx_i, 2'(L)};
        assign elem_l = addr_l - XW'(ph_l);
        assign shv    = value_i >> {ph_l, 3'b000};
        assign be_o[L] = (addr_l >= start_x) && ((elem_l + guard) < stop_x);
        assign data_o[8*L +: 8] = shv[7:0];
    end

    assign ph0_nxt_o = 2'((3'(ph0_i) + 3'd4) % per);
    assign nxt_base  = {1'b0, word_idx_i, 2'b00} + XW'(4);
    assign last_o    = (nxt_base - XW'(ph0_nxt_o) + guard) >= stop_x;

endmodule

// File: rtl/pattern_fill_engine.sv
module pattern_fill_engine
    import pfe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_we,
    output logic [AW-3:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    output logic [1:0]    irq
);

    localparam int NCH = 2;
    localparam int WW  = AW - 2;
    localparam int XW  = AW + 1;

    logic [AW-1:0] c_start [NCH];
    logic [AW-1:0] c_stop  [NCH];
    logic [31:0]   c_value [NCH];
    logic          c_sel24 [NCH];
    logic          c_sel32 [NCH];
    logic [NCH-1:0] c_pend;
    logic [NCH-1:0] c_fin;
    logic [NCH-1:0] done;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pfe_chan_regs #(.AW(AW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we && (reg_addr[2] == 1'(g))),
            .wr_sel    (reg_addr[1:0]),
            .wr_data   (reg_wdata),
            .fill_done (done[g]),
            .start_o   (c_start[g]),
            .stop_o    (c_stop[g]),
            .value_o   (c_value[g]),
            .sel24_o   (c_sel24[g]),
            .sel32_o   (c_sel32[g]),
            .pend_o    (c_pend[g]),
            .fin_o     (c_fin[g])
        );
    end

    typedef struct packed {
        logic           act;
        logic           ch;
        logic [WW-1:0]  widx;
        logic [1:0]     ph0;
        logic [NCH-1:0] irq;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          sel;
    logic [AW-1:0] s_start, s_stop;
    logic [31:0]   s_value;
    pat_e          s_pat;
    logic          has_work;
    logic [3:0]    wf_be;
    logic [31:0]   wf_data;
    logic [1:0]    wf_ph0_nxt;
    logic          wf_last;

    assign sel     = seq_q.act ? seq_q.ch : !c_pend[0];
    assign s_start = c_start[sel];
    assign s_stop  = c_stop[sel];
    assign s_value = c_value[sel];
    assign s_pat   = pat_decode(c_sel24[sel], c_sel32[sel]);

    assign has_work = (s_pat == PAT32) ? ({1'b0, s_stop} >= ({1'b0, s_start} + XW'(4)))
                                       : (s_stop > s_start);

    pfe_word_former #(.AW(AW)) u_former (
        .word_idx_i (seq_q.widx),
        .ph0_i      (seq_q.ph0),
        .start_i    (s_start),
        .stop_i     (s_stop),
        .value_i    (s_value),
        .pat_i      (s_pat),
        .be_o       (wf_be),
        .data_o     (wf_data),
        .ph0_nxt_o  (wf_ph0_nxt),
        .last_o     (wf_last)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = '0;
        done      = '0;
        if (seq_q.act) begin
            seq_d.widx = seq_q.widx + WW'(1);
            seq_d.ph0  = wf_ph0_nxt;
            if (wf_last) begin
                done[seq_q.ch] = 1'b1;
                seq_d.act      = 1'b0;
            end
        end else if (|c_pend) begin
            if (has_work) begin
                seq_d.act  = 1'b1;
                seq_d.ch   = sel;
                seq_d.widx = s_start[AW-1:2];
                seq_d.ph0  = first_phase(s_start[1:0], pat_period(s_pat));
            end else begin
                done[sel] = 1'b1;
            end
        end
        if (|done) seq_d.irq[sel] = (s_start != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign mem_we    = seq_q.act;
    assign mem_addr  = seq_q.widx;
    assign mem_be    = seq_q.act ? wf_be : 4'b0000;
    assign mem_wdata = wf_data;
    assign irq       = seq_q.irq;

    always_comb begin
        case (reg_addr[1:0])
            2'd0:    reg_rdata = 32'(c_start[reg_addr[2]]);
            2'd1:    reg_rdata = 32'(c_stop[reg_addr[2]]);
            2'd2:    reg_rdata = c_value[reg_addr[2]];
            default: reg_rdata = {28'd0, c_sel32[reg_addr[2]], c_sel24[reg_addr[2]],
                                  c_fin[reg_addr[2]], c_pend[reg_addr[2]]};
        endcase
    end

    // R9: completions never coincide
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R9: with channel 0 pending and the engine idle, channel 1 cannot be launched
    a_r9_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.act && c_pend[0]) |=> (!seq_q.act || !seq_q.ch));

    // R11: every write cycle touches at least one byte
    a_r11_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != 4'b0000));

    // R8: interrupt pulses follow a completion and find done already set
    a_r8_irq0_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> ($past(done[0]) && c_fin[0]));
    a_r8_irq1_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> ($past(done[1]) && c_fin[1]));

    // R8: interrupts last a single cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |=> !irq[0]);

endmodule

// File: tb/tb_pattern_fill_engine.sv
`timescale 1ns/1ps
module tb_pattern_fill_engine;

    localparam int AW = 8;
    localparam int MB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic [1:0]    irq;

    pattern_fill_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .irq(irq)
    );

    always #2 clk = ~clk;

    logic [7:0] act_mem [MB];
    logic [7:0] exp_mem [MB];
    int irq_cnt [2];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we)
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) act_mem[{mem_addr, 2'(l)}] = mem_wdata[8*l +: 8];
            if (irq[0]) irq_cnt[0]++;
            if (irq[1]) irq_cnt[1]++;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, want);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {1'(ch), 2'(sel)}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {1'(ch), 2'(sel)};
        #1 d = reg_rdata;
    endtask

    // expected image: element by element from the requirements
    task automatic model(input int s, input int e, input logic [31:0] v, input int m);
        int per;
        per = m[0] ? 3 : (m[1] ? 4 : 2);
        if (per == 4) begin
            for (int p = s; p + 4 <= e; p += 4)
                for (int i = 0; i < 4; i++) exp_mem[p+i] = v[8*i +: 8];
        end else begin
            for (int p = s; p < e; p += per)
                for (int i = 0; i < per; i++)
                    if (p + i < MB) exp_mem[p+i] = v[8*i +: 8];
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad_at;
        bad_at = -1;
        for (int a = 0; a < MB; a++)
            if (bad_at < 0 && act_mem[a] !== exp_mem[a]) bad_at = a;
        if (bad_at < 0) check(req, 32'd0, 32'd0);
        else check($sformatf("%s byte@%0d", req, bad_at), 32'(act_mem[bad_at]), 32'(exp_mem[bad_at]));
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] c;
        for (int t = 0; t < 400; t++) begin
            rd(ch, 3, c);
            if (!c[0]) break;
        end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic start_fill(input int ch, input int s, input int e, input logic [31:0] v, input int m);
        wr(ch, 0, 32'(s));
        wr(ch, 1, 32'(e));
        wr(ch, 2, v);
        wr(ch, 3, 32'((m << 2) | 1));
    endtask

    task automatic run_fill(input int ch, input int s, input int e, input logic [31:0] v, input int m);
        int i0, i1;
        logic [31:0] c;
        string tag;
        i0 = irq_cnt[0]; i1 = irq_cnt[1];
        start_fill(ch, s, e, v, m);
        wait_idle(ch);
        model(s, e, v, m);
        tag = (e <= s) ? "R2" : (m == 3 ? "R6" : (m == 1 ? "R4" : (m == 2 ? "R5" : "R3")));
        cmp_mem(tag);
        rd(ch, 3, c);
        check("R7 go/done", {30'd0, c[1:0]}, 32'd2);
        check("R8 irq own", 32'((ch == 0 ? irq_cnt[0] - i0 : irq_cnt[1] - i1)), 32'(s != 0));
        check("R8 irq other", 32'((ch == 0 ? irq_cnt[1] - i1 : irq_cnt[0] - i0)), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        for (int a = 0; a < MB; a++) begin act_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
        irq_cnt[0] = 0; irq_cnt[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        for (int ch = 0; ch < 2; ch++)
            for (int r = 0; r < 4; r++) begin
                rd(ch, r, c);
                check("R12 reg", c, 32'd0);
            end
        check("R12 mem_we", 32'(mem_we), 32'd0);
        check("R12 irq", 32'(irq), 32'd0);

        // R3 R4 R5 R6 R2 R7 R8: sweep widths, offsets, lengths
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 8; s++)
                for (int l = 0; l < 13; l++) begin
                    int st;
                    logic [31:0] v;
                    st = s + 56 * m;
                    v = {8'(s*7+1), 8'(l*13+5), 8'(m+8'hA0), 8'(s+l+8'h33)};
                    run_fill((s + l) % 2, st, st + l, v, m);
                end

        // R2: end below start
        run_fill(0, 40, 30, 32'hDEADBEEF, 0);
        run_fill(1, 0, 0, 32'hCAFEF00D, 2);

        // R1 R10: go clears done; writes to a busy channel are ignored
        start_fill(0, 128, 192, 32'h0000A55A, 0);
        rd(0, 3, c);
        check("R1 go set done clear", {30'd0, c[1:0]}, 32'd1);
        wr(0, 0, 32'd16);
        wr(0, 2, 32'h12345678);
        wr(0, 3, 32'h9);
        rd(0, 0, c);
        check("R10 start kept", c, 32'd128);
        wait_idle(0);
        model(128, 192, 32'h0000A55A, 0);
        cmp_mem("R10");
        rd(0, 2, c);
        check("R10 value kept", c, 32'h0000A55A);

        // R9 R11: second channel waits for the first; overlap order decides
        start_fill(0, 64, 128, 32'h00001122, 0);
        start_fill(1, 96, 160, 32'h33445566, 2);
        wait_idle(0);
        wait_idle(1);
        model(64, 128, 32'h00001122, 0);
        model(96, 160, 32'h33445566, 2);
        cmp_mem("R9 ch0 then ch1");
        start_fill(1, 70, 110, 32'h00778899, 1);
        start_fill(0, 90, 130, 32'h0000ABCD, 0);
        wait_idle(1);
        wait_idle(0);
        model(70, 110, 32'h00778899, 1);
        model(90, 130, 32'h0000ABCD, 0);
        cmp_mem("R9 ch1 then ch0");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule